// File: doc/BRIEF.md
# Serial Control Word Register Port

This block is the slave side of a three-wire control port for a stereo audio converter. A host shifts 16-bit command words in on a data line, one bit for each rising edge of a slow control clock, most significant bit first. When a latch line rises while chip select is held low, the captured word is committed to one of four banked configuration registers. The register is chosen by a two-bit address field inside the word. The block decodes the banked registers into steady control fields: per-channel attenuation, soft mute, de-emphasis enable and rate, DAC shutdown, input word format, word-clock polarity, filter roll-off, output phase inversion, clock-output halving and zero-detect mute.

All serial inputs are sampled into the system clock domain through synchronisers, and every decision is taken there. A mode pin picks the control source. In software mode the outputs come from the registers. In hardware mode a few static pins drive de-emphasis, mute and input format, and every other field takes its power-on default. The register contents are kept while hardware mode is active and take effect again when software mode returns.

Top module: `cfg_shift_port`

## Requirements
- R1: The committed word is the last 16 data bits captured on control-clock rising edges before the latch rise, with the first bit captured landing in B15 and the last in B0.
- R2: A latch rise commits the word to the register whose number is B10:B9 (0 to 3). The new setting appears on the outputs within SYNC_STAGES+1 system clocks of the latch rising at the pin.
- R3: After reset the outputs read attenL=attenR=8'hFF, muteOn=0, deemphOn=0, deemphRate=2'b10, dacOff=0, fmtCode=3'b000, and lrSwap, slowRoll, invertOut, clkHalf and zeroDetEn all 0.
- R4: In register 0, B7:B0 is the left attenuation and B8 is an apply bit. With B8=1 attenL takes B7:B0; with B8=0 attenL keeps its value. Register 1 drives attenR the same way.
- R5: Register 2 drives muteOn from B0, deemphOn from B1 and dacOff from B2. fmtCode is {B4,B3 of register 2, B0 of register 3}: 000 16-bit right-justified, 010 20-bit right-justified, 100 24-bit right-justified, 110 24-bit left-justified, 001 16-bit I2S, 011 24-bit I2S.
- R6: Register 3 drives lrSwap from B1, slowRoll from B3, invertOut from B4, clkHalf from B5, zeroDetEn from B8 and deemphRate from B7:B6. The rate codes are 01 for 48 kHz, 10 for 44.1 kHz and 11 for 32 kHz.
- R7: When register 3 B2 is 1, attenR shows register 0's attenuation. When it is 0, attenR shows register 1's attenuation.
- R8: A latch rise while csN is high changes no output.
- R9: A word with any of B15:B11 set is discarded and changes no output.
- R10: With swMode low, latch rises are ignored and attenL=attenR=8'hFF. muteOn is the inverse of hwMuteN. deemphOn is 1 when hwDeemph is non-zero, and deemphRate is hwDeemph (2'b10 when hwDeemph is 00). fmtCode is 000, 010, 001 or 011 for hwFmt 00, 01, 10 or 11. All other fields read 0.
- R11: Register contents survive a period in hardware mode and drive the outputs again once swMode returns high.
- R12: One latch rise produces exactly one commit. Without a commit, software-mode outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| swMode | input | 1 | 1 selects register control, 0 selects pin control |
| csN | input | 1 | Active-low chip select gating the latch |
| latchIn | input | 1 | Commit strobe; acts on its rising edge |
| sclkIn | input | 1 | Serial control clock |
| sdataIn | input | 1 | Serial control data, MSB first |
| hwDeemph | input | 2 | Pin de-emphasis selection in hardware mode |
| hwMuteN | input | 1 | Pin mute in hardware mode, low mutes |
| hwFmt | input | 2 | Pin input-format selection in hardware mode |
| attenL | output | 8 | Left attenuation code, FF is 0 dB |
| attenR | output | 8 | Right attenuation code |
| muteOn | output | 1 | Soft mute request |
| deemphOn | output | 1 | De-emphasis enable |
| deemphRate | output | 2 | De-emphasis rate code |
| dacOff | output | 1 | Force outputs to bipolar zero |
| fmtCode | output | 3 | Input word length and format code |
| lrSwap | output | 1 | Left channel on word-clock low |
| slowRoll | output | 1 | Slow roll-off filter select |
| invertOut | output | 1 | Invert analog output phase |
| clkHalf | output | 1 | Clock output at half rate |
| zeroDetEn | output | 1 | Zero-detect mute enable |

## Verification
The assertions check on every cycle that hardware mode forces full-scale attenuation, the pin-driven mute and defaults on the register-only fields. They also check that a commit never lasts two cycles and that left attenuation holds still while no commit occurs in software mode. Only the bench scenarios can show the field positions and the bit order, because these depend on what the host shifted in. The same holds for the apply bit, the shared-attenuation switch, discarding on chip select or reserved bits, and registers reappearing after hardware mode. A cycle-level reference model runs alongside the block and is compared against every output on every clock.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int WORD_W = 16;
  localparam int ATT_W  = 8;
  localparam int ADDR_LO = 9;
  localparam int RSV_LO  = 11;
  localparam int R2_W = 5;
  localparam int R3_W = 9;

  // strobes from the control side to the datapath
  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
    logic commit;
  } strb_t;
endpackage

// File: rtl/cfgp_ctrl.sv
module cfgp_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic swMode,
  input  logic csN,
  input  logic latchIn,
  input  logic sclkIn,
  input  logic sdataIn,
  output cfgp_pkg::strb_t strb
);
  // SYNC_STAGES must be at least 2
  logic [SYNC_STAGES-1:0] sclkSh, dataSh, latchSh, csSh;
  logic sclkPrev, latchPrev;
  logic sclkS, dataS, latchS, csS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSh    <= '0;
      dataSh    <= '0;
      latchSh   <= '0;
      csSh      <= '1;
      sclkPrev  <= 1'b0;
      latchPrev <= 1'b0;
    end else begin
      sclkSh    <= {sclkSh[SYNC_STAGES-2:0], sclkIn};
      dataSh    <= {dataSh[SYNC_STAGES-2:0], sdataIn};
      latchSh   <= {latchSh[SYNC_STAGES-2:0], latchIn};
      csSh      <= {csSh[SYNC_STAGES-2:0], csN};
      sclkPrev  <= sclkS;
      latchPrev <= latchS;
    end
  end

  assign sclkS  = sclkSh[SYNC_STAGES-1];
  assign dataS  = dataSh[SYNC_STAGES-1];
  assign latchS = latchSh[SYNC_STAGES-1];
  assign csS    = csSh[SYNC_STAGES-1];

  always_comb begin
    strb.shiftEn  = sclkS & ~sclkPrev;
    strb.shiftBit = dataS;
    strb.commit   = latchS & ~latchPrev & ~csS & swMode;
  end
endmodule

// File: rtl/cfgp_data.sv
module cfgp_data
  import cfgp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strb_t            strb,
  input  logic             swMode,
  input  logic [1:0]       hwDeemph,
  input  logic             hwMuteN,
  input  logic [1:0]       hwFmt,
  output logic [ATT_W-1:0] attenL,
  output logic [ATT_W-1:0] attenR,
  output logic             muteOn,
  output logic             deemphOn,
  output logic [1:0]       deemphRate,
  output logic             dacOff,
  output logic [2:0]       fmtCode,
  output logic             lrSwap,
  output logic             slowRoll,
  output logic             invertOut,
  output logic             clkHalf,
  output logic             zeroDetEn
);
  localparam int NUM_REGS = 4;

  logic [WORD_W-1:0] shiftReg;
  logic [ATT_W-1:0]  attLReg, attRReg;
  logic [R2_W-1:0]   ctl2Reg;
  logic [R3_W-1:0]   ctl3Reg;
  logic              wordOk;
  logic [1:0]        wordAddr;
  logic [NUM_REGS-1:0] selReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strb.shiftEn) shiftReg <= {shiftReg[WORD_W-2:0], strb.shiftBit};
  end

  assign wordOk   = (shiftReg[WORD_W-1:RSV_LO] == '0);
  assign wordAddr = shiftReg[ADDR_LO+1:ADDR_LO];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign selReg[g] = strb.commit & wordOk & (wordAddr == 2'(g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      attLReg <= '1;
      attRReg <= '1;
      ctl2Reg <= '0;
      ctl3Reg <= R3_W'(9'h080);
    end else begin
      if (selReg[0] && shiftReg[ATT_W]) attLReg <= shiftReg[ATT_W-1:0];
      if (selReg[1] && shiftReg[ATT_W]) attRReg <= shiftReg[ATT_W-1:0];
      if (selReg[2]) ctl2Reg <= shiftReg[R2_W-1:0];
      if (selReg[3]) ctl3Reg <= shiftReg[R3_W-1:0];
    end
  end

  always_comb begin
    if (swMode) begin
      attenL     = attLReg;
      attenR     = ctl3Reg[2] ? attLReg : attRReg;
      muteOn     = ctl2Reg[0];
      deemphOn   = ctl2Reg[1];
      dacOff     = ctl2Reg[2];
      fmtCode    = {ctl2Reg[4:3], ctl3Reg[0]};
      lrSwap     = ctl3Reg[1];
      slowRoll   = ctl3Reg[3];
      invertOut  = ctl3Reg[4];
      clkHalf    = ctl3Reg[5];
      deemphRate = ctl3Reg[7:6];
      zeroDetEn  = ctl3Reg[8];
    end else begin
      attenL     = '1;
      attenR     = '1;
      muteOn     = ~hwMuteN;
      deemphOn   = |hwDeemph;
      dacOff     = 1'b0;
      fmtCode    = {1'b0, hwFmt[0], hwFmt[1]};
      lrSwap     = 1'b0;
      slowRoll   = 1'b0;
      invertOut  = 1'b0;
      clkHalf    = 1'b0;
      deemphRate = (hwDeemph == 2'b00) ? 2'b10 : hwDeemph;
      zeroDetEn  = 1'b0;
    end
  end
endmodule

// File: rtl/cfg_shift_port.sv
module cfg_shift_port #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       swMode,
  input  logic       csN,
  input  logic       latchIn,
  input  logic       sclkIn,
  input  logic       sdataIn,
  input  logic [1:0] hwDeemph,
  input  logic       hwMuteN,
  input  logic [1:0] hwFmt,
  output logic [7:0] attenL,
  output logic [7:0] attenR,
  output logic       muteOn,
  output logic       deemphOn,
  output logic [1:0] deemphRate,
  output logic       dacOff,
  output logic [2:0] fmtCode,
  output logic       lrSwap,
  output logic       slowRoll,
  output logic       invertOut,
  output logic       clkHalf,
  output logic       zeroDetEn
);
  cfgp_pkg::strb_t strb;

  cfgp_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .swMode(swMode), .csN(csN), .latchIn(latchIn),
    .sclkIn(sclkIn), .sdataIn(sdataIn), .strb(strb)
  );

  cfgp_data u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .swMode(swMode),
    .hwDeemph(hwDeemph), .hwMuteN(hwMuteN), .hwFmt(hwFmt),
    .attenL(attenL), .attenR(attenR), .muteOn(muteOn), .deemphOn(deemphOn),
    .deemphRate(deemphRate), .dacOff(dacOff), .fmtCode(fmtCode),
    .lrSwap(lrSwap), .slowRoll(slowRoll), .invertOut(invertOut),
    .clkHalf(clkHalf), .zeroDetEn(zeroDetEn)
  );
endmodule

// File: rtl/cfgp_chk.sv
module cfgp_chk (
  input logic       clk,
  input logic       rstN,
  input logic       swMode,
  input logic       hwMuteN,
  input logic       commit,
  input logic [7:0] attenL,
  input logic [7:0] attenR,
  input logic       muteOn,
  input logic       lrSwap,
  input logic       slowRoll,
  input logic       invertOut,
  input logic       clkHalf,
  input logic       zeroDetEn
);
  AST_HW_FULL_SCALE: assert property (@(posedge clk) disable iff (!rstN)
    !swMode |-> (attenL == 8'hFF) && (attenR == 8'hFF)); // R10

  AST_HW_PIN_MUTE: assert property (@(posedge clk) disable iff (!rstN)
    !swMode |-> muteOn == !hwMuteN); // R10

  AST_HW_DEFAULTS: assert property (@(posedge clk) disable iff (!rstN)
    !swMode |-> !(lrSwap || slowRoll || invertOut || clkHalf || zeroDetEn)); // R10

  AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    commit |=> !commit); // R12

  AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    (!commit && swMode) |=> (!swMode || $stable(attenL))); // R12
endmodule

bind cfg_shift_port cfgp_chk u_chk (
  .clk(clk), .rstN(rstN), .swMode(swMode), .hwMuteN(hwMuteN),
  .commit(strb.commit), .attenL(attenL), .attenR(attenR), .muteOn(muteOn),
  .lrSwap(lrSwap), .slowRoll(slowRoll), .invertOut(invertOut),
  .clkHalf(clkHalf), .zeroDetEn(zeroDetEn)
);

// File: tb/sim_cfg_shift_port.sv
`timescale 1ns/1ps
module sim_cfg_shift_port;
  localparam int SYNC = 2;
  localparam int LAT  = SYNC + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic swMode = 1'b1, csN = 1'b1, latchIn = 1'b0, sclkIn = 1'b0, sdataIn = 1'b0;
  logic [1:0] hwDeemph = 2'b00, hwFmt = 2'b00;
  logic hwMuteN = 1'b1;
  logic [7:0] attenL, attenR;
  logic muteOn, deemphOn, dacOff, lrSwap, slowRoll, invertOut, clkHalf, zeroDetEn;
  logic [1:0] deemphRate;
  logic [2:0] fmtCode;

  int nChk = 0, nFail = 0;
  bit cmpOn = 0;
  bit done = 0;

  // reference model state
  logic [7:0] mAttL, mAttR;
  logic [4:0] mR2;
  logic [8:0] mR3;
  logic [15:0] pendWord;
  bit pendOk = 0;
  int cd = 0;

  always #2 clk = ~clk;

  cfg_shift_port #(.SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rstN(rstN), .swMode(swMode), .csN(csN), .latchIn(latchIn),
    .sclkIn(sclkIn), .sdataIn(sdataIn), .hwDeemph(hwDeemph), .hwMuteN(hwMuteN),
    .hwFmt(hwFmt), .attenL(attenL), .attenR(attenR), .muteOn(muteOn),
    .deemphOn(deemphOn), .deemphRate(deemphRate), .dacOff(dacOff),
    .fmtCode(fmtCode), .lrSwap(lrSwap), .slowRoll(slowRoll),
    .invertOut(invertOut), .clkHalf(clkHalf), .zeroDetEn(zeroDetEn)
  );

  task automatic modelReset();
    mAttL = 8'hFF; mAttR = 8'hFF; mR2 = '0; mR3 = 9'h080; cd = 0;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // model commit: applies on the LAT-th rising edge after the latch rise
  always @(posedge clk) begin
    if (cd == 1 && pendOk) begin
      case (pendWord[10:9])
        2'd0: if (pendWord[8]) mAttL = pendWord[7:0];
        2'd1: if (pendWord[8]) mAttR = pendWord[7:0];
        2'd2: mR2 = pendWord[4:0];
        default: mR3 = pendWord[8:0];
      endcase
    end
    if (cd > 0) cd--;
  end

  task automatic compareAll();
    if (swMode) begin
      chk(attenL, mAttL, "R4 attenL");
      chk(attenR, mR3[2] ? mAttL : mAttR, "R7 attenR");
      chk({7'd0, muteOn}, {7'd0, mR2[0]}, "R5 muteOn");
      chk({7'd0, deemphOn}, {7'd0, mR2[1]}, "R5 deemphOn");
      chk({7'd0, dacOff}, {7'd0, mR2[2]}, "R5 dacOff");
      chk({5'd0, fmtCode}, {5'd0, mR2[4:3], mR3[0]}, "R5 fmtCode");
      chk({7'd0, lrSwap}, {7'd0, mR3[1]}, "R6 lrSwap");
      chk({7'd0, slowRoll}, {7'd0, mR3[3]}, "R6 slowRoll");
      chk({7'd0, invertOut}, {7'd0, mR3[4]}, "R6 invertOut");
      chk({7'd0, clkHalf}, {7'd0, mR3[5]}, "R6 clkHalf");
      chk({6'd0, deemphRate}, {6'd0, mR3[7:6]}, "R6 deemphRate");
      chk({7'd0, zeroDetEn}, {7'd0, mR3[8]}, "R6 zeroDetEn");
    end else begin
      chk(attenL, 8'hFF, "R10 attenL");
      chk(attenR, 8'hFF, "R10 attenR");
      chk({7'd0, muteOn}, {7'd0, ~hwMuteN}, "R10 muteOn");
      chk({7'd0, deemphOn}, {7'd0, |hwDeemph}, "R10 deemphOn");
      chk({6'd0, deemphRate}, {6'd0, (hwDeemph == 2'b00) ? 2'b10 : hwDeemph}, "R10 deemphRate");
      chk({5'd0, fmtCode}, (hwFmt == 2'b00) ? 8'h0 : (hwFmt == 2'b01) ? 8'h2 :
                           (hwFmt == 2'b10) ? 8'h1 : 8'h3, "R10 fmtCode");
      chk({7'd0, dacOff | lrSwap | slowRoll | invertOut | clkHalf | zeroDetEn}, 8'h0,
          "R10 defaults");
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (cmpOn) compareAll();
  end

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // shift a word MSB first, then pulse the latch with the given chip select
  task automatic sendWord(input logic [15:0] w, input logic csVal);
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk);
      sdataIn = w[i];
      sclkIn = 1'b0;
      ticks(4);
      sclkIn = 1'b1;
      ticks(4);
    end
    sclkIn = 1'b0;
    csN = csVal;
    ticks(3);
    latchIn = 1'b1;
    pendWord = w;
    pendOk = (csVal == 1'b0) && swMode && (w[15:11] == 5'd0);
    cd = LAT;
    ticks(4);
    latchIn = 1'b0;
    csN = 1'b1;
    ticks(4);
  endtask

  initial begin
    modelReset();
    ticks(5);
    rstN = 1'b1;
    ticks(1);
    @(posedge clk); #1;
    // R3: reset state
    chk(attenL, 8'hFF, "R3 attenL");
    chk(attenR, 8'hFF, "R3 attenR");
    chk({6'd0, deemphRate}, 8'h2, "R3 deemphRate");
    chk({5'd0, fmtCode}, 8'h0, "R3 fmtCode");
    chk({7'd0, muteOn | deemphOn | dacOff | lrSwap | slowRoll | invertOut | clkHalf | zeroDetEn},
        8'h0, "R3 flags");
    cmpOn = 1;

    // R1/R2: MSB-first word into register 0 with apply bit set
    sendWord(16'h0180, 1'b0);
    chk(attenL, 8'h80, "R1 msb first attenL");
    sendWord(16'h015A, 1'b0);
    chk(attenL, 8'h5A, "R2 register 0 commit");
    // R4: apply bit clear leaves attenuation
    sendWord(16'h0011, 1'b0);
    chk(attenL, 8'h5A, "R4 no apply");
    sendWord(16'h0333, 1'b0);
    chk(attenR, 8'h33, "R4 register 1 commit");
    // R5: register 2 fields
    sendWord(16'h0417, 1'b0);
    chk({7'd0, muteOn}, 8'h1, "R5 mute set");
    chk({5'd0, fmtCode}, 8'h4, "R5 fmt 24-bit right");
    // R6: register 3 fields
    sendWord(16'h07AB, 1'b0);
    chk({6'd0, deemphRate}, 8'h2, "R6 rate");
    chk({7'd0, zeroDetEn}, 8'h1, "R6 zero detect");
    chk({5'd0, fmtCode}, 8'h5, "R5 fmt code with i2s bit");
    // R7: shared attenuation
    sendWord(16'h0604, 1'b0);
    chk(attenR, 8'h5A, "R7 common attenuation");
    sendWord(16'h0600, 1'b0);
    chk(attenR, 8'h33, "R7 separate attenuation");
    // R8: chip select high blocks commit
    sendWord(16'h0100, 1'b1);
    chk(attenL, 8'h5A, "R8 cs high ignored");
    // R9: reserved bits discard
    sendWord(16'h8122, 1'b0);
    chk(attenL, 8'h5A, "R9 reserved discarded");
    // boundary: attenuation code zero
    sendWord(16'h0100, 1'b0);
    chk(attenL, 8'h00, "R4 zero code");
    sendWord(16'h06C0, 1'b0);
    chk({6'd0, deemphRate}, 8'h3, "R6 rate 32k");

    // R10: hardware mode
    @(negedge clk);
    swMode = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      hwDeemph = 2'(k);
      hwFmt = 2'(3 - k);
      hwMuteN = k[0];
      ticks(3);
    end
    sendWord(16'h01EE, 1'b0);
    chk(attenL, 8'hFF, "R10 hw attenuation");
    // R11: back to software mode
    @(negedge clk);
    swMode = 1'b1;
    ticks(2);
    chk(attenL, 8'h00, "R11 register kept");
    chk({6'd0, deemphRate}, 8'h3, "R11 rate kept");
    ticks(4);

    done = 1;
    cmpOn = 0;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog run did not finish");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule